// File: doc/BRIEF.md
# Link Mode Reconfiguration Sequencer

This block moves a four-lane Ethernet link from one operating mode to another. It does this by running one fixed series of accesses on a simple memory-mapped master port. One start pulse, together with a 3-bit target-mode code and a loopback enable, launches a run. The run goes through these phases in order:

- turn the serial interface off;
- hold the transmit and receive soft resets;
- reset the analog front end;
- reload the default settings of every channel;
- write the registers for the chosen mode;
- turn the interface back on;
- pulse the reconfiguration reset;
- hold the soft resets again;
- set loopback;
- start adaptation and poll its status;
- release the soft resets.

The transceiver, MAC and FEC sit behind the register bus and are not part of this block.

Every access is held on the bus until the slave lowers its wait request. The mode-specific register values come from a small lookup inside the block. Adaptation status is polled up to a programmable number of reads. If it never reports completion, the run stops with the resets still held and the error flag set. An out-of-range mode code is rejected at once and causes no bus traffic.

The address is `{space[2:0], channel[1:0], offset[10:0]}`. The spaces are: 0 Ethernet, 1 transceiver, 2 FEC, 3 reconfiguration control, 4 PMA attribute. Mode codes are: 0 100G RS-FEC, 1 100G KP-FEC, 2 100G RS-FEC 544, 3 100G no FEC, 4 4x25G RS-FEC, 5 4x25G no FEC.

Top module: `lmr_seq_top`

## Requirements
- R1: After reset, busy, done and err are low. No bus read or write is asserted whenever busy is low.
- R2: A start pulse while idle with mode code 0..5 raises busy on the next cycle. The first access is a write of 0 to attribute offset 0x001, which turns the serial interface off.
- R3: The accesses that follow the first one are, in order: a write of 0x6 to Ethernet 0x310, then a write of 1 to attribute 0x002 (analog reset).
- R4: After the analog reset comes one write of 0x01 to transceiver offset 0x091 for each channel, with the channel field taking the values 0, 1, 2, 3 in turn.
- R5: Four mode writes follow, in this order:
  - Ethernet 0x300: 0x1 for 100G modes, 0x4 for 4x25G modes.
  - Transceiver channel 0, 0x0A0: 0x26 for modes 1 and 2, otherwise 0x25.
  - FEC 0x004: 1 for RS-FEC, 2 for KP-FEC, 3 for RS-FEC 544, 0 for no FEC.
  - Reconfiguration 0x010: the mode code.
- R6: Next come these writes, in order:
  - 1 to attribute 0x001 (interface on);
  - 1 then 0 to reconfiguration 0x00E;
  - 0x6 to Ethernet 0x310.
- R7: A write to attribute 0x008 carrying the loopback enable latched at start comes next, followed by a write of 1 to attribute 0x00A that starts adaptation.
- R8: A request keeps its address, data and direction unchanged while wait request is high. Read and write are never asserted together.
- R9: Attribute 0x00B is read repeatedly until it returns exactly 0x1. Then 0x0 is written to Ethernet 0x310, which ends the run.
- R10: If adapt_limit reads of 0x00B return something other than 0x1 (a limit of 0 counts as 1), the run stops: err goes high, busy goes low, and no release write is made.
- R11: A start while idle with mode code 6 or 7 sets err on the next cycle. It causes no bus access, and busy stays low.
- R12: A start pulse while busy is ignored. The sequence, the mode and the loopback value already latched are not affected.
- R13: Done is a single-cycle pulse in the cycle after the release write is accepted. An accepted start clears err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse |
| mode | input | 3 | Target mode code |
| loopback_en | input | 1 | Internal serial loopback enable, latched at start |
| adapt_limit | input | 16 | Maximum number of adaptation status reads |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse at successful completion |
| err | output | 1 | Rejected mode code or adaptation timeout |
| bus_addr | output | 16 | Access address {space, channel, offset} |
| bus_wdata | output | 32 | Write data |
| bus_write | output | 1 | Write request |
| bus_read | output | 1 | Read request |
| bus_waitreq | input | 1 | Slave stall; the access is taken in a cycle where it is low |
| bus_rdata | input | 32 | Read data, valid in the accepting cycle |

## Verification
The assertions check the following on every cycle:
- a request stays stable while stalled;
- read and write never overlap;
- the bus is silent while idle;
- done is a single pulse that follows an accepted release write;
- a rejected mode or an expired poll ends in err with an idle bus.

Only the bench's scenarios can show the full ordering of the access list, the per-mode lookup values, the latched loopback value, the poll count at the limit boundary, and that a start during a run changes nothing. They do this by comparing the logged access stream with an expected list built from the requirements.

// File: rtl/lmr_pkg.sv
package lmr_pkg;

  localparam int ADDR_W    = 16;
  localparam int DATA_W    = 32;
  localparam int MODE_WRS  = 4;
  localparam int MIDX_W    = $clog2(MODE_WRS);
  localparam int NUM_MODES = 6;

  localparam logic [2:0] SP_ETH  = 3'd0;
  localparam logic [2:0] SP_XCVR = 3'd1;
  localparam logic [2:0] SP_FEC  = 3'd2;
  localparam logic [2:0] SP_RCFG = 3'd3;
  localparam logic [2:0] SP_ATTR = 3'd4;

  localparam logic [10:0] OFF_SOFTRST  = 11'h310;
  localparam logic [10:0] OFF_RELOAD   = 11'h091;
  localparam logic [10:0] OFF_RCFG_RST = 11'h00E;
  localparam logic [10:0] OFF_SER_EN   = 11'h001;
  localparam logic [10:0] OFF_ANA_RST  = 11'h002;
  localparam logic [10:0] OFF_LOOP     = 11'h008;
  localparam logic [10:0] OFF_ADAPT_GO = 11'h00A;
  localparam logic [10:0] OFF_ADAPT_ST = 11'h00B;

  typedef struct packed {
    logic              rd;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } bus_op_t;

  function automatic logic [ADDR_W-1:0] mk_addr(logic [2:0] sp, logic [1:0] ch, logic [10:0] off);
    return {sp, ch, off};
  endfunction

  function automatic bus_op_t wr_op(logic [2:0] sp, logic [1:0] ch, logic [10:0] off, logic [DATA_W-1:0] d);
    bus_op_t o;
    o.rd   = 1'b0;
    o.addr = mk_addr(sp, ch, off);
    o.data = d;
    return o;
  endfunction

  function automatic logic mode_valid(logic [2:0] m);
    return int'(m) < NUM_MODES;
  endfunction

  function automatic logic [DATA_W-1:0] fec_code(logic [2:0] m);
    case (m)
      3'd0, 3'd4: return 32'd1;
      3'd1:       return 32'd2;
      3'd2:       return 32'd3;
      default:    return 32'd0;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] lane_cfg(logic [2:0] m);
    return (m >= 3'd4) ? 32'h4 : 32'h1;
  endfunction

  function automatic logic [DATA_W-1:0] rate_code(logic [2:0] m);
    return (m == 3'd1 || m == 3'd2) ? 32'h26 : 32'h25;
  endfunction

  // effective poll limit: zero is treated as one read
  function automatic logic [16:0] eff_limit(logic [15:0] lim);
    return (lim == 16'd0) ? 17'd1 : {1'b0, lim};
  endfunction

endpackage

// File: rtl/lmr_mode_table.sv
module lmr_mode_table
  import lmr_pkg::*;
(
  input  logic [2:0]        mode,
  input  logic [MIDX_W-1:0] idx,
  output bus_op_t           op
);

  always_comb begin
    case (idx)
      MIDX_W'(0): op = wr_op(SP_ETH,  2'd0, 11'h300, lane_cfg(mode));
      MIDX_W'(1): op = wr_op(SP_XCVR, 2'd0, 11'h0A0, rate_code(mode));
      MIDX_W'(2): op = wr_op(SP_FEC,  2'd0, 11'h004, fec_code(mode));
      default:    op = wr_op(SP_RCFG, 2'd0, 11'h010, {29'd0, mode});
    endcase
  end

endmodule

// File: rtl/lmr_bus_port.sv
module lmr_bus_port
  import lmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  bus_op_t           op,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              bus_write,
  output logic              bus_read,
  input  logic              bus_waitreq,
  output logic              acc
);

  assign bus_addr  = op.addr;
  assign bus_wdata = op.data;
  assign bus_write = req && !op.rd;
  assign bus_read  = req && op.rd;
  assign acc       = req && !bus_waitreq;

  // R8: stalled request holds its contents
  p_hold_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_write || bus_read) && bus_waitreq |=>
      (bus_write || bus_read) && $stable(bus_addr) && $stable(bus_wdata) && $stable(bus_write));

  // R8: one direction at a time
  p_one_dir_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_write && bus_read));

endmodule

// File: rtl/lmr_poll_timer.sv
module lmr_poll_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit,
  output logic             last_try
);

  logic [CNT_W:0] cnt_q;
  logic [CNT_W:0] eff;

  always_comb begin
    eff = (limit == '0) ? (CNT_W+1)'(1) : {1'b0, limit};
  end

  assign last_try = (cnt_q + (CNT_W+1)'(1)) >= eff;

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= '0;
    else if (clr)  cnt_q <= '0;
    else if (tick) cnt_q <= cnt_q + (CNT_W+1)'(1);
  end

  // R10: a new run starts with a fresh poll count
  p_cnt_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt_q == '0);

endmodule

// File: rtl/lmr_seq_top.sv
module lmr_seq_top
  import lmr_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        mode,
  input  logic              loopback_en,
  input  logic [CNT_W-1:0]  adapt_limit,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              bus_write,
  output logic              bus_read,
  input  logic              bus_waitreq,
  input  logic [DATA_W-1:0] bus_rdata
);

  localparam int RLD0   = 3;
  localparam int MODE0  = RLD0 + NUM_CH;
  localparam int EN     = MODE0 + MODE_WRS;
  localparam int RR1    = EN + 1;
  localparam int RR0    = EN + 2;
  localparam int HOLD2  = EN + 3;
  localparam int LB     = EN + 4;
  localparam int ADS    = EN + 5;
  localparam int POLL   = EN + 6;
  localparam int REL    = EN + 7;
  localparam int STEP_W = $clog2(REL + 1);

  logic              busy_q, done_q, err_q, lb_q;
  logic [2:0]        mode_q;
  logic [STEP_W-1:0] step_q;
  logic [MIDX_W-1:0] mode_idx;
  bus_op_t           cur_op, mode_op;

  // named internal events
  logic start_ok, start_bad, acc, poll_acc, poll_ok, poll_miss, tmo_hit, fin_acc, last_try;

  assign start_ok  = start && !busy_q && mode_valid(mode);
  assign start_bad = start && !busy_q && !mode_valid(mode);

  assign mode_idx = MIDX_W'(int'(step_q) - MODE0);

  lmr_mode_table u_tab (
    .mode (mode_q),
    .idx  (mode_idx),
    .op   (mode_op)
  );

  always_comb begin
    int s;
    s = int'(step_q);
    cur_op = wr_op(SP_ETH, 2'd0, OFF_SOFTRST, 32'h0);
    if (s == 0)              cur_op = wr_op(SP_ATTR, 2'd0, OFF_SER_EN, 32'h0);
    else if (s == 1)         cur_op = wr_op(SP_ETH,  2'd0, OFF_SOFTRST, 32'h6);
    else if (s == 2)         cur_op = wr_op(SP_ATTR, 2'd0, OFF_ANA_RST, 32'h1);
    else if (s < MODE0)      cur_op = wr_op(SP_XCVR, 2'(s - RLD0), OFF_RELOAD, 32'h1);
    else if (s < EN)         cur_op = mode_op;
    else if (s == EN)        cur_op = wr_op(SP_ATTR, 2'd0, OFF_SER_EN, 32'h1);
    else if (s == RR1)       cur_op = wr_op(SP_RCFG, 2'd0, OFF_RCFG_RST, 32'h1);
    else if (s == RR0)       cur_op = wr_op(SP_RCFG, 2'd0, OFF_RCFG_RST, 32'h0);
    else if (s == HOLD2)     cur_op = wr_op(SP_ETH,  2'd0, OFF_SOFTRST, 32'h6);
    else if (s == LB)        cur_op = wr_op(SP_ATTR, 2'd0, OFF_LOOP, {31'd0, lb_q});
    else if (s == ADS)       cur_op = wr_op(SP_ATTR, 2'd0, OFF_ADAPT_GO, 32'h1);
    else if (s == POLL) begin
      cur_op    = wr_op(SP_ATTR, 2'd0, OFF_ADAPT_ST, 32'h0);
      cur_op.rd = 1'b1;
    end
  end

  lmr_bus_port u_bus (
    .clk         (clk),
    .rst_n       (rst_n),
    .req         (busy_q),
    .op          (cur_op),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_write   (bus_write),
    .bus_read    (bus_read),
    .bus_waitreq (bus_waitreq),
    .acc         (acc)
  );

  assign poll_acc  = acc && (int'(step_q) == POLL);
  assign poll_ok   = poll_acc && (bus_rdata == 32'h1);
  assign poll_miss = poll_acc && (bus_rdata != 32'h1);
  assign tmo_hit   = poll_miss && last_try;
  assign fin_acc   = acc && (int'(step_q) == REL);

  lmr_poll_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (start_ok),
    .tick     (poll_miss),
    .limit    (adapt_limit),
    .last_try (last_try)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      lb_q   <= 1'b0;
      mode_q <= '0;
      step_q <= '0;
    end else begin
      done_q <= fin_acc;
      if (start_ok) begin
        busy_q <= 1'b1;
        err_q  <= 1'b0;
        step_q <= '0;
        mode_q <= mode;
        lb_q   <= loopback_en;
      end else if (start_bad) begin
        err_q <= 1'b1;
      end else if (busy_q) begin
        if (tmo_hit) begin
          busy_q <= 1'b0;
          err_q  <= 1'b1;
        end else if (fin_acc) begin
          busy_q <= 1'b0;
        end else if (acc && (int'(step_q) != POLL || poll_ok)) begin
          step_q <= step_q + STEP_W'(1);
        end
      end
    end
  end

  assign busy = busy_q;
  assign done = done_q;
  assign err  = err_q;

  // R1: bus silent while idle
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !bus_write && !bus_read);

  // R2: accepted start opens with interface disable
  p_first_access_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok |=> busy && bus_write && bus_addr == mk_addr(SP_ATTR, 2'd0, OFF_SER_EN) && bus_wdata == 32'h0);

  // R9: done only follows an accepted release write
  p_done_after_rel_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(bus_write && !bus_waitreq && bus_addr == mk_addr(SP_ETH, 2'd0, OFF_SOFTRST) && bus_wdata == 32'h0));

  // R10: expired poll ends the run in error
  p_tmo_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_hit |=> err && !busy && !bus_write && !bus_read);

  // R11: rejected mode raises error with no traffic
  p_bad_mode_r11: assert property (@(posedge clk) disable iff (!rst_n)
    start_bad |=> err && !busy && !bus_write && !bus_read);

  // R13: done is a single pulse
  p_done_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: tb/lmr_seq_top_tb_top.sv
module lmr_seq_top_tb_top;

  typedef struct packed {
    logic [2:0]  mode;
    logic        lb;
    logic [3:0]  stall;
    logic [3:0]  ready_at;
    logic [15:0] lim;
    logic        exp_err;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    vec_t'{3'd0, 1'b1, 4'd0, 4'd1, 16'd4, 1'b0},
    vec_t'{3'd1, 1'b0, 4'd2, 4'd3, 16'd4, 1'b0},
    vec_t'{3'd2, 1'b1, 4'd1, 4'd2, 16'd2, 1'b0},
    vec_t'{3'd3, 1'b1, 4'd0, 4'd1, 16'd0, 1'b0},
    vec_t'{3'd4, 1'b0, 4'd3, 4'd0, 16'd3, 1'b1},
    vec_t'{3'd5, 1'b1, 4'd0, 4'd5, 16'd8, 1'b0},
    vec_t'{3'd2, 1'b0, 4'd0, 4'd0, 16'd0, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  mode = 3'd0;
  logic        loopback_en = 1'b0;
  logic [15:0] adapt_limit = 16'd0;
  logic        busy, done, err;
  logic [15:0] bus_addr;
  logic [31:0] bus_wdata;
  logic        bus_write, bus_read;
  logic        bus_waitreq = 1'b1;
  logic [31:0] bus_rdata = 32'd0;

  always #5 clk = ~clk;

  lmr_seq_top dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .loopback_en(loopback_en),
    .adapt_limit(adapt_limit), .busy(busy), .done(done), .err(err),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_write(bus_write), .bus_read(bus_read),
    .bus_waitreq(bus_waitreq), .bus_rdata(bus_rdata)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // bus slave model and access log
  int          stall_cfg = 0, ready_cfg = 0, stall_left = 0, poll_n = 0;
  int          log_n = 0, done_cnt = 0;
  logic [15:0] lg_addr [64];
  logic [31:0] lg_data [64];
  logic        lg_rd   [64];
  logic        rel_prev = 1'b0;

  always @(negedge clk) begin
    if (rel_prev) chk(done === 1'b1, "R13 done after release", done, 1);
    rel_prev = 1'b0;
    if (done) done_cnt++;
    if (bus_write || bus_read) begin
      if (stall_left > 0) begin
        bus_waitreq = 1'b1;
        stall_left--;
      end else begin
        bus_waitreq = 1'b0;
        if (log_n < 64) begin
          lg_addr[log_n] = bus_addr;
          lg_data[log_n] = bus_wdata;
          lg_rd[log_n]   = bus_read;
        end
        log_n++;
        if (bus_read) begin
          poll_n++;
          bus_rdata = (ready_cfg != 0 && poll_n == ready_cfg) ? 32'h1 : 32'h0;
        end
        if (bus_write && bus_addr == 16'h0310 && bus_wdata == 32'h0) rel_prev = 1'b1;
        stall_left = stall_cfg;
      end
    end else begin
      bus_waitreq = 1'b1;
    end
  end

  // expected access list, built from the requirements
  int          ex_n;
  logic [15:0] ex_addr [64];
  logic [31:0] ex_data [64];
  logic        ex_rd   [64];
  string       ex_tag  [64];

  function automatic logic [15:0] adr(int sp, int ch, int off);
    return 16'(sp * 16'h2000 + ch * 16'h0800 + off);
  endfunction

  task automatic push(input int sp, input int ch, input int off, input int d, input logic rd, input string tag);
    ex_addr[ex_n] = adr(sp, ch, off);
    ex_data[ex_n] = 32'(d);
    ex_rd[ex_n]   = rd;
    ex_tag[ex_n]  = tag;
    ex_n++;
  endtask

  task automatic build(input vec_t v);
    int eff, nrd, fec;
    logic ok;
    ex_n = 0;
    push(4, 0, 'h001, 0, 0, "R2");
    push(0, 0, 'h310, 6, 0, "R3");
    push(4, 0, 'h002, 1, 0, "R3");
    for (int c = 0; c < 4; c++) push(1, c, 'h091, 1, 0, "R4");
    case (int'(v.mode)) 0: fec = 1; 1: fec = 2; 2: fec = 3; 4: fec = 1; default: fec = 0; endcase
    push(0, 0, 'h300, (v.mode < 4) ? 1 : 4, 0, "R5");
    push(1, 0, 'h0A0, (v.mode == 1 || v.mode == 2) ? 'h26 : 'h25, 0, "R5");
    push(2, 0, 'h004, fec, 0, "R5");
    push(3, 0, 'h010, int'(v.mode), 0, "R5");
    push(4, 0, 'h001, 1, 0, "R6");
    push(3, 0, 'h00E, 1, 0, "R6");
    push(3, 0, 'h00E, 0, 0, "R6");
    push(0, 0, 'h310, 6, 0, "R6");
    push(4, 0, 'h008, int'(v.lb), 0, "R7");
    push(4, 0, 'h00A, 1, 0, "R7");
    eff = (v.lim == 0) ? 1 : int'(v.lim);
    ok  = (v.ready_at != 0) && (int'(v.ready_at) <= eff);
    nrd = ok ? int'(v.ready_at) : eff;
    for (int r = 0; r < nrd; r++) push(4, 0, 'h00B, 0, 1, ok ? "R9" : "R10");
    if (ok) push(0, 0, 'h310, 0, 0, "R9");
  endtask

  task automatic run(input vec_t v, input int poke_at);
    build(v);
    stall_cfg = int'(v.stall); ready_cfg = int'(v.ready_at);
    stall_left = int'(v.stall); poll_n = 0; log_n = 0; done_cnt = 0;
    @(negedge clk); #1;
    mode = v.mode; loopback_en = v.lb; adapt_limit = v.lim; start = 1'b1;
    @(negedge clk); #1;
    start = 1'b0;
    chk(busy === 1'b1, "R2 busy after start", busy, 1);
    for (int c = 1; c < 3000; c++) begin
      @(negedge clk); #1;
      if (c == poke_at) begin
        mode = 3'd3; loopback_en = ~v.lb; start = 1'b1;   // R12 start while busy
      end else begin
        start = 1'b0;
      end
      if (!busy) break;
    end
    start = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk(log_n == ex_n, "R3 access count", log_n, ex_n);
    for (int i = 0; i < ex_n && i < log_n && i < 64; i++) begin
      chk(lg_addr[i] == ex_addr[i] && lg_rd[i] == ex_rd[i] && (ex_rd[i] || lg_data[i] == ex_data[i]),
          $sformatf("%s access %0d addr/data", ex_tag[i], i),
          {lg_addr[i], lg_data[i]}, {ex_addr[i], ex_data[i]});
    end
    chk(err === v.exp_err, v.exp_err ? "R10 err after timeout" : "R13 err clear", err, v.exp_err);
    chk(done_cnt == (v.exp_err ? 0 : 1), "R13 done pulse count", done_cnt, v.exp_err ? 0 : 1);
    chk(busy === 1'b0, "R9 idle at end", busy, 0);
  endtask

  task automatic bad_mode(input logic [2:0] m);
    log_n = 0;
    @(negedge clk); #1;
    mode = m; start = 1'b1;
    @(negedge clk); #1;
    start = 1'b0;
    chk(err === 1'b1, "R11 err on bad mode", err, 1);
    chk(busy === 1'b0, "R11 busy stays low", busy, 0);
    repeat (5) @(negedge clk);
    #1;
    chk(log_n == 0, "R11 no bus access", log_n, 0);
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(busy === 1'b0 && done === 1'b0 && err === 1'b0, "R1 reset outputs", {busy, done, err}, 0);
    chk(bus_write === 1'b0 && bus_read === 1'b0, "R1 bus idle in reset", {bus_write, bus_read}, 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(busy === 1'b0 && bus_write === 1'b0 && bus_read === 1'b0, "R1 idle after reset", busy, 0);

    for (int k = 0; k < NV; k++) run(VECS[k], 0);

    // R11 rejected codes, then R13 accepted start clears err
    bad_mode(3'd6);
    bad_mode(3'd7);
    run(VECS[0], 0);

    // R12 start (with other mode and loopback) in the middle of a run
    run(VECS[1], 6);
    run(VECS[2], 30);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule